// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation converter. Software writes a control byte that picks one of three analog inputs (or ground) and requests a conversion. The sequencer then steers the input multiplexer, walks a trial code on a resistor-ladder DAC from the most significant bit down, and samples an external comparator once per bit. The final code lands in a pair of result registers, and a completion flag in the control byte tells a polling routine that the value is ready.

A conversion always takes the same number of ADC clocks: a settling period, then a fixed window per bit. The result registers keep the previous value for the whole conversion and change only on its final clock, so software never reads a half-built code. The analog comparator, ladder and multiplexer are outside the block.

Top module: `sar_conv_seq`

## Requirements
- R1: A conversion of an input with integer level v (0 to 1023 ladder steps) yields v. Bits are decided MSB first, and a bit stays 1 when the comparator reports the input at or above the trial level (cmp_in = 1).
- R2: A start write sampled at clock edge E0 starts the conversion at edge E1. The result registers and the completion flag update at edge E51, which makes 50 conversion clocks: 10 of settling, then 4 per bit.
- R3: Control field [7:4] picks the input. Codes 0, 1 and 2 drive mux_sel to 0, 1 and 2. Every other code drives mux_sel to 3 (ground), which converts to 0. mux_sel is fixed for the whole conversion.
- R4: Writing control bit 0 = 1 while idle requests a conversion. Bit 0 reads 1 after the write and clears itself at the edge where the conversion begins.
- R5: Control bit 3 is the completion flag. A start write clears it. It reads 1 from edge E51 on and stays 1 until the next start write.
- R6: result_hi holds result bits [9:2]. result_lo[1:0] holds result bits [1:0], and result_lo[7:2] reads 0.
- R7: result_hi and result_lo keep the previous conversion's value until edge E51 of the new one.
- R8: dac_code is 0 while idle and during settling. In the slot of bit b it equals the bits already decided, with bit b set to 1 and lower bits 0. The comparator is sampled on the 4th clock of the slot.
- R9: A control write while a conversion is pending or running is ignored. The control byte, the channel and the completion timing are unchanged.
- R10: After reset, ctrl_rdata, result_hi, result_lo, dac_code and mux_sel are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control write data: [7:4] channel, [0] start |
| ctrl_rdata | output | 8 | Control readback: [7:4] channel, [3] completion flag, [0] start pending |
| cmp_in | input | 1 | Comparator result, 1 when input >= dac_code |
| dac_code | output | 10 | Trial code to the resistor-ladder DAC |
| mux_sel | output | 2 | Input multiplexer select, 3 = ground |
| result_hi | output | 8 | Result bits [9:2] |
| result_lo | output | 8 | Result bits [1:0] in [1:0], rest 0 |

## Verification
On every cycle, the assertions check the 50-clock run length, a stable result during a conversion, the completion flag rising after the final clock and cleared by a start, writes ignored while busy, a steady multiplexer select and an idle DAC code of zero. The bench's scenarios are needed for the rest: the converted value for each channel and level, including ground codes and full-scale and zero inputs. They also cover the exact trial codes on the ladder during settling and the first two bit slots, and the edge at which the old result is replaced.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int CTRL_W     = 8;
  localparam int CHAN_W     = 4;
  localparam int SEL_W      = 2;
  localparam int NUM_INPUTS = 3;
  localparam int START_BIT  = 0;
  localparam int DONE_BIT   = 3;
  localparam int CHAN_LSB   = 4;
  localparam logic [SEL_W-1:0] SEL_GND = 2'd3;

  // Channel code to multiplexer select: unknown codes tie the input to ground.
  function automatic logic [SEL_W-1:0] chan_to_sel(input logic [CHAN_W-1:0] code);
    if (int'(code) < NUM_INPUTS) return code[SEL_W-1:0];
    return SEL_GND;
  endfunction
endpackage

// File: rtl/sar_ctrl_reg.sv
module sar_ctrl_reg
  import sar_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              busy,
  input  logic              done,
  output logic [CHAN_W-1:0] chan,
  output logic              launch,
  output logic [CTRL_W-1:0] rdata
);
  logic start_pend;
  logic done_flag;
  logic accept;
  logic unused_wbits;

  assign unused_wbits = ^wdata[DONE_BIT:START_BIT+1];
  assign accept = wr && !busy && !start_pend;
  assign launch = start_pend && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan       <= '0;
      start_pend <= 1'b0;
      done_flag  <= 1'b0;
    end else begin
      if (accept) begin
        chan <= wdata[CHAN_LSB +: CHAN_W];
        if (wdata[START_BIT]) begin
          start_pend <= 1'b1;
          done_flag  <= 1'b0;
        end
      end else if (launch) begin
        start_pend <= 1'b0;
      end
      if (done) done_flag <= 1'b1;
    end
  end

  always_comb begin
    rdata = '0;
    rdata[CHAN_LSB +: CHAN_W] = chan;
    rdata[DONE_BIT]           = done_flag;
    rdata[START_BIT]          = start_pend;
  end
endmodule

// File: rtl/sar_timer.sv
module sar_timer #(
  parameter int RES_BITS     = 10,
  parameter int SETUP_CLKS   = 10,
  parameter int CLKS_PER_BIT = 4,
  localparam int CONV_CLKS   = SETUP_CLKS + RES_BITS * CLKS_PER_BIT,
  localparam int CNT_W       = $clog2(CONV_CLKS),
  localparam int IDX_W       = $clog2(RES_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  output logic             busy,
  output logic             in_slot,
  output logic             bit_sample,
  output logic             done,
  output logic [IDX_W-1:0] bit_idx
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] offset;
  logic [CNT_W-1:0] slot;
  logic [CNT_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (done) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    offset     = cnt - CNT_W'(SETUP_CLKS);
    slot       = offset / CNT_W'(CLKS_PER_BIT);
    phase      = offset % CNT_W'(CLKS_PER_BIT);
    in_slot    = busy && (cnt >= CNT_W'(SETUP_CLKS));
    bit_idx    = IDX_W'(RES_BITS - 1) - IDX_W'(slot);
    bit_sample = in_slot && (phase == CNT_W'(CLKS_PER_BIT - 1));
    done       = busy && (cnt == CNT_W'(CONV_CLKS - 1));
  end
endmodule

// File: rtl/sar_approx.sv
module sar_approx #(
  parameter int RES_BITS = 10,
  localparam int IDX_W   = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch,
  input  logic                in_slot,
  input  logic                bit_sample,
  input  logic [IDX_W-1:0]    bit_idx,
  input  logic                cmp_in,
  output logic [RES_BITS-1:0] dac_code,
  output logic [RES_BITS-1:0] sar_next
);
  logic [RES_BITS-1:0] sar_q;

  function automatic logic [RES_BITS-1:0] bit_mask(input logic [IDX_W-1:0] idx);
    return {{(RES_BITS-1){1'b0}}, 1'b1} << idx;
  endfunction

  function automatic logic [RES_BITS-1:0] trial(input logic [RES_BITS-1:0] held,
                                                input logic [IDX_W-1:0] idx);
    return held | bit_mask(idx);
  endfunction

  function automatic logic [RES_BITS-1:0] decide(input logic [RES_BITS-1:0] held,
                                                 input logic [IDX_W-1:0] idx,
                                                 input logic keep);
    return keep ? (held | bit_mask(idx)) : (held & ~bit_mask(idx));
  endfunction

  assign sar_next = bit_sample ? decide(sar_q, bit_idx, cmp_in) : sar_q;
  assign dac_code = in_slot ? trial(sar_q, bit_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sar_q <= '0;
    else if (launch) sar_q <= '0;
    else             sar_q <= sar_next;
  end
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_pkg::*;
#(
  parameter int RES_BITS     = 10,
  parameter int SETUP_CLKS   = 10,
  parameter int CLKS_PER_BIT = 4,
  localparam int CONV_CLKS   = SETUP_CLKS + RES_BITS * CLKS_PER_BIT,
  localparam int LO_BITS     = 2,
  localparam int HI_BITS     = RES_BITS - LO_BITS,
  localparam int IDX_W       = $clog2(RES_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctrl_wr,
  input  logic [CTRL_W-1:0]   ctrl_wdata,
  output logic [CTRL_W-1:0]   ctrl_rdata,
  input  logic                cmp_in,
  output logic [RES_BITS-1:0] dac_code,
  output logic [SEL_W-1:0]    mux_sel,
  output logic [HI_BITS-1:0]  result_hi,
  output logic [7:0]          result_lo
);
  logic [CHAN_W-1:0]   chan;
  logic                launch;
  logic                busy;
  logic                in_slot;
  logic                bit_sample;
  logic                done;
  logic [IDX_W-1:0]    bit_idx;
  logic [RES_BITS-1:0] sar_next;
  logic [LO_BITS-1:0]  lo_q;

  sar_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(ctrl_wdata),
    .busy(busy), .done(done), .chan(chan), .launch(launch), .rdata(ctrl_rdata)
  );

  sar_timer #(.RES_BITS(RES_BITS), .SETUP_CLKS(SETUP_CLKS), .CLKS_PER_BIT(CLKS_PER_BIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .launch(launch), .busy(busy), .in_slot(in_slot),
    .bit_sample(bit_sample), .done(done), .bit_idx(bit_idx)
  );

  sar_approx #(.RES_BITS(RES_BITS)) u_approx (
    .clk(clk), .rst_n(rst_n), .launch(launch), .in_slot(in_slot),
    .bit_sample(bit_sample), .bit_idx(bit_idx), .cmp_in(cmp_in),
    .dac_code(dac_code), .sar_next(sar_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_sel   <= '0;
      result_hi <= '0;
      lo_q      <= '0;
    end else begin
      if (launch) mux_sel <= chan_to_sel(chan);
      if (done) begin
        result_hi <= sar_next[RES_BITS-1:LO_BITS];
        lo_q      <= sar_next[LO_BITS-1:0];
      end
    end
  end

  assign result_lo = {{(8-LO_BITS){1'b0}}, lo_q};
endmodule

// File: rtl/sar_conv_seq_chk.sv
module sar_conv_seq_chk #(
  parameter int RES_BITS  = 10,
  parameter int CONV_CLKS = 50,
  localparam int RUN_W    = $clog2(CONV_CLKS) + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ctrl_wr,
  input logic [7:0]          ctrl_wdata,
  input logic [7:0]          ctrl_rdata,
  input logic [RES_BITS-1:0] dac_code,
  input logic [1:0]          mux_sel,
  input logic [RES_BITS-3:0] result_hi,
  input logic [7:0]          result_lo,
  input logic                busy,
  input logic                done
);
  logic [RUN_W-1:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     run_len <= '0;
    else if (!busy) run_len <= '0;
    else            run_len <= run_len + 1'b1;
  end

  AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> run_len == RUN_W'(CONV_CLKS - 1)); // R2

  AST_EOC_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ctrl_rdata[3]); // R5

  AST_START_CLEARS_EOC: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_wdata[0] && !busy && !ctrl_rdata[0]) |=> (!ctrl_rdata[3] && ctrl_rdata[0])); // R4

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(result_hi) && $stable(result_lo))); // R7

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && busy && !done) |=> $stable(ctrl_rdata)); // R9

  AST_MUX_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(mux_sel)); // R3

  AST_DAC_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> dac_code == '0); // R8
endmodule

bind sar_conv_seq sar_conv_seq_chk #(.RES_BITS(RES_BITS), .CONV_CLKS(CONV_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
  .ctrl_rdata(ctrl_rdata), .dac_code(dac_code), .mux_sel(mux_sel),
  .result_hi(result_hi), .result_lo(result_lo), .busy(busy), .done(done)
);

// File: tb/sar_conv_seq_bench.sv
module sar_conv_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {channel[43:40], in0[39:30], in1[29:20], in2[19:10], expected[9:0]}
  localparam logic [43:0] VECS [NVEC] = '{
    {4'h0, 10'h2A5, 10'h155, 10'h0F0, 10'h2A5},
    {4'h1, 10'h3FF, 10'h200, 10'h000, 10'h200},
    {4'h2, 10'h100, 10'h3FF, 10'h1FF, 10'h1FF},
    {4'h3, 10'h3FF, 10'h3FF, 10'h3FF, 10'h000},
    {4'hF, 10'h155, 10'h2AA, 10'h3FF, 10'h000},
    {4'h0, 10'h3FF, 10'h000, 10'h000, 10'h3FF},
    {4'h0, 10'h000, 10'h3FF, 10'h3FF, 10'h000},
    {4'h2, 10'h3FF, 10'h3FF, 10'h001, 10'h001}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_wr = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic [7:0] ctrl_rdata;
  logic       cmp_in;
  logic [9:0] dac_code;
  logic [1:0] mux_sel;
  logic [7:0] result_hi;
  logic [7:0] result_lo;
  logic [9:0] vin [3];
  logic [9:0] level;
  logic [9:0] prev_res = 10'h000;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural multiplexer and comparator; select 3 is ground.
  always_comb begin
    level  = (mux_sel == 2'd3) ? 10'h000 : vin[mux_sel];
    cmp_in = (level >= dac_code);
  end

  sar_conv_seq u_sar_conv_seq (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .cmp_in(cmp_in), .dac_code(dac_code),
    .mux_sel(mux_sel), .result_hi(result_hi), .result_lo(result_lo)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_conv(input logic [3:0] chan, input logic [9:0] exp, input bit inject);
    logic [1:0] sel;
    sel = (chan < 4'd3) ? chan[1:0] : 2'd3;
    @(negedge clk);
    ctrl_wr = 1'b1;
    ctrl_wdata = {chan, 4'h1};
    @(posedge clk);                      // E0
    @(negedge clk);
    ctrl_wr = 1'b0;
    chk("R4 start pending", 16'(ctrl_rdata), 16'({chan, 4'h1}));
    chk("R5 flag cleared by start", 16'(ctrl_rdata[3]), 16'd0);
    for (int n = 1; n <= 51; n++) begin
      if (inject && n == 5) begin
        ctrl_wr = 1'b1;
        ctrl_wdata = {4'h2, 4'h1};
      end
      @(posedge clk);
      @(negedge clk);
      if (inject && n == 5) begin
        ctrl_wr = 1'b0;
        chk("R9 write while busy", 16'(ctrl_rdata), 16'({chan, 4'h0}));
      end
      if (n == 1) begin
        chk("R4 start self-clears", 16'(ctrl_rdata[0]), 16'd0);
        chk("R3 mux select", 16'(mux_sel), 16'(sel));
        chk("R8 dac zero in settling", 16'(dac_code), 16'h000);
      end
      if (n == 11) chk("R8 msb trial", 16'(dac_code), 16'h200);
      if (n == 15) chk("R8 second trial", 16'(dac_code), 16'((exp & 10'h200) | 10'h100));
      if (n == 50) begin
        chk("R2 flag low before end", 16'(ctrl_rdata[3]), 16'd0);
        chk("R7 old result held", 16'({result_hi, result_lo[1:0]}), 16'(prev_res));
      end
      if (n == 51) begin
        chk("R2 flag at end", 16'(ctrl_rdata[3]), 16'd1);
        chk("R1 result value", 16'({result_hi, result_lo[1:0]}), 16'(exp));
        chk("R6 result_hi", 16'(result_hi), 16'(exp[9:2]));
        chk("R6 result_lo", 16'(result_lo), 16'({6'b0, exp[1:0]}));
      end
    end
    prev_res = exp;
  endtask

  initial begin
    vin[0] = 10'h000; vin[1] = 10'h000; vin[2] = 10'h000;
    repeat (3) @(negedge clk);
    chk("R10 ctrl reset", 16'(ctrl_rdata), 16'h00);
    chk("R10 result reset", 16'({result_hi, result_lo}), 16'h0000);
    chk("R10 dac reset", 16'(dac_code), 16'h000);
    chk("R10 mux reset", 16'(mux_sel), 16'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      vin[0] = VECS[i][39:30];
      vin[1] = VECS[i][29:20];
      vin[2] = VECS[i][19:10];
      run_conv(VECS[i][43:40], VECS[i][9:0], 1'b0);
    end

    // Start request during a running conversion is ignored (R9).
    vin[0] = 10'h000; vin[1] = 10'h12C; vin[2] = 10'h3FF;
    run_conv(4'h1, 10'h12C, 1'b1);

    // Completion flag persists while idle (R5).
    repeat (10) @(negedge clk);
    chk("R5 flag persists", 16'(ctrl_rdata), 16'h18);
    chk("R7 result stays", 16'({result_hi, result_lo[1:0]}), 16'h12C);

    // Channel-only write while idle does not start (R4).
    ctrl_wr = 1'b1; ctrl_wdata = 8'h20;
    @(negedge clk);
    ctrl_wr = 1'b0;
    repeat (60) @(negedge clk);
    chk("R4 no start without bit 0", 16'(ctrl_rdata), 16'h28);
    chk("R7 no result change", 16'({result_hi, result_lo[1:0]}), 16'h12C);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule